// File: doc/BRIEF.md
# Byte-Coded Zero-Register Stack Processor

This block is a 32-bit processor core whose only architectural registers are a program counter and a stack pointer. Every operand sits on a stack held in data memory. The core reads one opcode byte per instruction from a byte-addressed instruction memory. It reads and writes whole 32-bit words through a separate data memory port. Both memory ports are synchronous, and read data returns one cycle after the address.

A small set of operations runs in hardware. These cover immediate building, stack-relative loads, stores and adds, memory load and store, add, and, or, not, bit reversal and stack or flow control. Opcodes in a fixed block of 32 codes are traps: the core pushes the return address and jumps into a vector table, so software can supply the missing operations. A parameter lets one code in that block, subtract, run natively instead of trapping. A break opcode stops the core so that the stack can be inspected.

The stack pointer points at the top-of-stack word. A push writes at SP-4 and then lowers SP by 4. A pop raises SP by 4. Each instruction runs in a fixed sequence of five cycles: fetch, decode with a top-of-stack read, a second operand read, a wait for data, and execute. At most one data write happens per instruction, and it happens in the execute cycle.

Top module: `stk_core`

## Requirements
- R1: While reset is held, halted is 0, dmem_we is 0 and imem_addr equals RESET_PC.
- R2: Every instruction takes exactly 5 clock cycles. After N instructions followed by a break, halted rises on the 5*(N+1)-th rising edge after reset is released.
- R3: An opcode 1xxxxxxx is an immediate. If the previous instruction was not an immediate, it pushes the sign-extended low 7 bits. Otherwise it replaces TOS with (TOS<<7)|low7.
- R4: Opcodes 0x05 (add), 0x06 (and) and 0x07 (or) pop two words and push the result. With NATIVE_SUB=1, code 0x31 pops two words and pushes NOS-TOS without trapping.
- R5: Opcode 0x09 replaces TOS with its bitwise inverse. Opcode 0x0A replaces TOS with its 32 bits in reverse order.
- R6: An opcode 011ooooo pushes the word at SP+4*o, where o ranges over the full 0 to 31 and SP is the value before the push.
- R7: An opcode 010ooooo pops TOS and writes it to SP+4*o, where SP is the value before the pop and o ranges over 0 to 31.
- R8: An opcode 0001oooo replaces TOS with TOS plus the word at SP+4*o.
- R9: Opcode 0x0C pops an address and then a value, and stores the value at that address. Opcode 0x08 replaces TOS with the word at address TOS.
- R10: Opcode 0x02 pushes the SP value as it was before the push. Opcode 0x0D pops a word into SP. Opcode 0x04 pops a word into PC.
- R11: A trap opcode 001iiiii that is not native pushes PC+1 and continues at VEC_BASE+32*i.
- R12: Opcode 0x00 halts the core. Halted then stays high until reset, with no further data reads or writes and a fixed imem_addr.
- R13: Opcodes 0x01, 0x03, 0x0B, 0x0E and 0x0F change nothing but PC. Like every non-immediate, they end an immediate chain, so the next immediate pushes a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the opcode to fetch (the PC) |
| imem_data | input | 8 | Opcode byte, valid the cycle after imem_addr |
| dmem_addr | output | 32 | Word address (byte address, 4-aligned) for read or write |
| dmem_re | output | 1 | Data read enable |
| dmem_we | output | 1 | Data write enable |
| dmem_wdata | output | 32 | Data write word |
| dmem_rdata | input | 32 | Data read word, valid the cycle after dmem_addr |
| halted | output | 1 | Core stopped by a break opcode |

## Verification
Every instruction takes five cycles, and its single data write lands in the fifth. So a straight-line program of N instructions and a break raises halted exactly 5*(N+1) edges after reset is released. The bench counts rising edges from reset release and samples halted 1 ns after each edge. It compares the count with that formula, or with an explicit figure for programs that jump or trap. Results are read from the bench's own stack memory only after halted is seen. By that point the last write has completed, and R12 guarantees that no later write can disturb it.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int DW   = 32;
  localparam int OPW  = 8;
  localparam int OFFW = 5;
  localparam int WB   = DW / 8;

  typedef enum logic [4:0] {
    OP_NOP, OP_BREAK, OP_IMM, OP_PUSHSP, OP_POPPC, OP_ADD, OP_AND, OP_OR,
    OP_SUB, OP_LOAD, OP_NOT, OP_FLIP, OP_STORE, OP_POPSP, OP_ADDSP,
    OP_STORESP, OP_LOADSP, OP_TRAP
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_RDA, ST_RDB, ST_EXE, ST_HALT
  } st_e;

  function automatic logic [DW-1:0] bit_reverse(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int k = 0; k < DW; k++) r[k] = v[DW-1-k];
    return r;
  endfunction

  function automatic logic [DW-1:0] sext7(input logic [6:0] v);
    return {{(DW-7){v[6]}}, v};
  endfunction

  function automatic logic [DW-1:0] slot_addr(input logic [DW-1:0] sp,
                                              input logic [OFFW-1:0] off);
    return sp + DW'(WB) * DW'(off);
  endfunction
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
#(
  parameter bit NATIVE_SUB = 1'b1
) (
  input  logic [OPW-1:0]  opcode,
  output op_e             op,
  output logic [OFFW-1:0] arg
);
  logic sub_hit;

  generate
    if (NATIVE_SUB) begin : g_sub
      assign sub_hit = (opcode == 8'h31);
    end else begin : g_nosub
      assign sub_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    op  = OP_NOP;
    arg = opcode[OFFW-1:0];
    if (opcode[7]) begin
      op = OP_IMM;
    end else if (opcode[6:5] == 2'b11) begin
      op = OP_LOADSP;
    end else if (opcode[6:5] == 2'b10) begin
      op = OP_STORESP;
    end else if (opcode[6:5] == 2'b01) begin
      op = sub_hit ? OP_SUB : OP_TRAP;
    end else if (opcode[4]) begin
      op  = OP_ADDSP;
      arg = {1'b0, opcode[3:0]};
    end else begin
      unique case (opcode[3:0])
        4'h0: op = OP_BREAK;
        4'h2: op = OP_PUSHSP;
        4'h4: op = OP_POPPC;
        4'h5: op = OP_ADD;
        4'h6: op = OP_AND;
        4'h7: op = OP_OR;
        4'h8: op = OP_LOAD;
        4'h9: op = OP_NOT;
        4'hA: op = OP_FLIP;
        4'hC: op = OP_STORE;
        4'hD: op = OP_POPSP;
        default: op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/stk_exec.sv
module stk_exec
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] VEC_BASE = 32'h400
) (
  input  op_e             op,
  input  logic [OFFW-1:0] arg,
  input  logic [6:0]      imm7,
  input  logic            imm_cont,
  input  logic [DW-1:0]   pc,
  input  logic [DW-1:0]   sp,
  input  logic [DW-1:0]   tos,
  input  logic [DW-1:0]   opb,
  output logic            wr_en,
  output logic [DW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   sp_next,
  output logic [DW-1:0]   pc_next,
  output logic            stop
);
  localparam logic [DW-1:0] STEP = DW'(WB);

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = sp;
    wr_data = '0;
    sp_next = sp;
    pc_next = pc + 1'b1;
    stop    = 1'b0;
    unique case (op)
      OP_BREAK: begin
        stop    = 1'b1;
        pc_next = pc;
      end
      OP_IMM: begin
        wr_en = 1'b1;
        if (imm_cont) begin
          wr_data = {tos[DW-8:0], imm7};
        end else begin
          wr_addr = sp - STEP;
          wr_data = sext7(imm7);
          sp_next = sp - STEP;
        end
      end
      OP_PUSHSP: begin
        wr_en = 1'b1; wr_addr = sp - STEP; wr_data = sp; sp_next = sp - STEP;
      end
      OP_POPPC: begin
        pc_next = tos; sp_next = sp + STEP;
      end
      OP_ADD, OP_AND, OP_OR, OP_SUB: begin
        wr_en   = 1'b1;
        wr_addr = sp + STEP;
        sp_next = sp + STEP;
        unique case (op)
          OP_ADD:  wr_data = opb + tos;
          OP_AND:  wr_data = opb & tos;
          OP_OR:   wr_data = opb | tos;
          default: wr_data = opb - tos;
        endcase
      end
      OP_LOAD:  begin wr_en = 1'b1; wr_data = opb; end
      OP_NOT:   begin wr_en = 1'b1; wr_data = ~tos; end
      OP_FLIP:  begin wr_en = 1'b1; wr_data = bit_reverse(tos); end
      OP_ADDSP: begin wr_en = 1'b1; wr_data = tos + opb; end
      OP_STORE: begin
        wr_en = 1'b1; wr_addr = tos; wr_data = opb; sp_next = sp + 2 * STEP;
      end
      OP_POPSP: sp_next = tos;
      OP_STORESP: begin
        wr_en = 1'b1; wr_addr = slot_addr(sp, arg); wr_data = tos;
        sp_next = sp + STEP;
      end
      OP_LOADSP: begin
        wr_en = 1'b1; wr_addr = sp - STEP; wr_data = opb; sp_next = sp - STEP;
      end
      OP_TRAP: begin
        wr_en   = 1'b1;
        wr_addr = sp - STEP;
        wr_data = pc + 1'b1;
        sp_next = sp - STEP;
        pc_next = VEC_BASE + {{(DW-OFFW-5){1'b0}}, arg, 5'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] RESET_PC   = 32'h0,
  parameter logic [DW-1:0] RESET_SP   = 32'h400,
  parameter logic [DW-1:0] VEC_BASE   = 32'h400,
  parameter bit            NATIVE_SUB = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [31:0]   imem_addr,
  input  logic [7:0]    imem_data,
  output logic [31:0]   dmem_addr,
  output logic          dmem_re,
  output logic          dmem_we,
  output logic [31:0]   dmem_wdata,
  input  logic [31:0]   dmem_rdata,
  output logic          halted
);
  st_e            st;
  logic [DW-1:0]  pc, sp, a_q, b_q;
  logic [OPW-1:0] opc_q;
  logic           imm_flag;

  op_e            op;
  logic [OFFW-1:0] arg;
  logic           x_we, x_stop;
  logic [DW-1:0]  x_addr, x_data, x_sp, x_pc;
  logic [DW-1:0]  second_addr;

  stk_decode #(.NATIVE_SUB(NATIVE_SUB)) u_dec (
    .opcode(opc_q), .op(op), .arg(arg)
  );

  stk_exec #(.VEC_BASE(VEC_BASE)) u_exe (
    .op(op), .arg(arg), .imm7(opc_q[6:0]), .imm_cont(imm_flag),
    .pc(pc), .sp(sp), .tos(a_q), .opb(b_q),
    .wr_en(x_we), .wr_addr(x_addr), .wr_data(x_data),
    .sp_next(x_sp), .pc_next(x_pc), .stop(x_stop)
  );

  // events brought out for the checker
  logic ev_exec, ev_trap, ev_imm_ext;
  assign ev_exec    = (st == ST_EXE);
  assign ev_trap    = ev_exec && (op == OP_TRAP);
  assign ev_imm_ext = ev_exec && (op == OP_IMM) && imm_flag;

  // the second operand comes from a stack slot, from memory at TOS, or from NOS
  always_comb begin
    unique case (op)
      OP_LOADSP, OP_ADDSP: second_addr = slot_addr(sp, arg);
      OP_LOAD:             second_addr = dmem_rdata;
      default:             second_addr = sp + DW'(WB);
    endcase
  end

  always_comb begin
    imem_addr  = pc;
    dmem_re    = 1'b0;
    dmem_we    = 1'b0;
    dmem_addr  = sp;
    dmem_wdata = x_data;
    unique case (st)
      ST_DEC: dmem_re = 1'b1;
      ST_RDA: begin dmem_re = 1'b1; dmem_addr = second_addr; end
      ST_EXE: begin dmem_we = x_we; dmem_addr = x_addr; end
      default: ;
    endcase
  end

  assign halted = (st == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_FETCH;
      pc       <= RESET_PC;
      sp       <= RESET_SP;
      a_q      <= '0;
      b_q      <= '0;
      opc_q    <= '0;
      imm_flag <= 1'b0;
    end else begin
      unique case (st)
        ST_FETCH: st <= ST_DEC;
        ST_DEC: begin
          opc_q <= imem_data;
          st    <= ST_RDA;
        end
        ST_RDA: begin
          a_q <= dmem_rdata;
          st  <= ST_RDB;
        end
        ST_RDB: begin
          b_q <= dmem_rdata;
          st  <= ST_EXE;
        end
        ST_EXE: begin
          pc       <= x_pc;
          sp       <= x_sp;
          imm_flag <= (op == OP_IMM);
          st       <= x_stop ? ST_HALT : ST_FETCH;
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter logic [31:0] VEC_BASE = 32'h400
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic        dmem_re,
  input logic        dmem_we,
  input logic        halted,
  input logic        ev_exec,
  input logic        ev_trap,
  input logic        ev_imm_ext
);
  p_exec_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exec |=> !ev_exec);
  p_write_in_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> ev_exec);
  p_imm_ext_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_imm_ext |-> dmem_we);
  p_trap_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |-> dmem_we);
  p_trap_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> (imem_addr[4:0] == VEC_BASE[4:0]));
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!dmem_we && !dmem_re));
  p_halt_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr));
endmodule

bind stk_core stk_core_chk #(.VEC_BASE(VEC_BASE)) i_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_re(dmem_re),
  .dmem_we(dmem_we), .halted(halted), .ev_exec(ev_exec), .ev_trap(ev_trap),
  .ev_imm_ext(ev_imm_ext)
);

// File: tb/test_stk_core.sv
`timescale 1ns/1ps
module test_stk_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [7:0]  imem_data;
  logic        dmem_re, dmem_we, halted;

  always #5 clk = ~clk;

  stk_core i_stk_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halted(halted)
  );

  logic [7:0]  imem [0:2047];
  logic [31:0] dmem [0:511];

  always @(posedge clk) begin
    imem_data  <= imem[imem_addr[10:0]];
    dmem_rdata <= dmem[dmem_addr[10:2]];
    if (dmem_we) dmem[dmem_addr[10:2]] <= dmem_wdata;
  end

  int n_tests = 0, n_fail = 0;
  int pos, n_ins, cyc;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE0000 + i;
  endfunction
  function automatic logic [31:0] m_sext(input logic [6:0] b);
    return (b >= 7'd64) ? (32'(b) - 32'd128) : 32'(b);
  endfunction
  function automatic logic [31:0] m_rev(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) if (v[k]) r = r | (32'h80000000 >> k);
    return r;
  endfunction
  function automatic logic [31:0] rd(input int byte_addr);
    return dmem[byte_addr / 4];
  endfunction

  task automatic clr_prog();
    for (int i = 0; i < 2048; i++) imem[i] = 8'h00;
    pos = 0; n_ins = 0;
  endtask
  task automatic put(input logic [7:0] b);
    imem[pos] = b; pos++; n_ins++;
  endtask
  task automatic put_const(input logic [31:0] v);
    put(8'h80 | {4'h0, v[31:28]});
    put(8'h80 | {1'b0, v[27:21]});
    put(8'h80 | {1'b0, v[20:14]});
    put(8'h80 | {1'b0, v[13:7]});
    put(8'h80 | {1'b0, v[6:0]});
    put(8'h0B);
  endtask

  task automatic run();
    rst_n = 1'b0;
    for (int i = 0; i < 512; i++) dmem[i] = pat(i);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(posedge clk); cyc++; #1;
    end
  endtask

  // binary op helper: push x, push y, op, PUSHSP, BREAK
  task automatic bin_test(input string tag, input logic [7:0] opc,
                          input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] exp);
    clr_prog(); put_const(x); put_const(y); put(opc); put(8'h02); put(8'h00);
    run();
    check({tag, " result"}, rd(32'h3FC), exp);
    check({tag, " sp"}, rd(32'h3F8), 32'h3FC);
    check({tag, " cycles"}, cyc, 5 * n_ins);
  endtask

  initial begin : main
    logic [31:0] vals [0:7];
    vals = '{32'h0, 32'hFFFFFFFF, 32'h1, 32'h80000000,
             32'h12345678, 32'hDEADBEEF, 32'h7FFFFFFF, 32'h0F0F00F1};

    // R1: reset state
    clr_prog();
    repeat (3) @(posedge clk);
    #1;
    check("R1 halted in reset", halted, 0);
    check("R1 no write in reset", dmem_we, 0);
    check("R1 fetch addr", imem_addr, 32'h0);

    // R12 / R2: lone break
    clr_prog(); put(8'h00);
    run();
    check("R2 break cycles", cyc, 5);
    check("R12 halted", halted, 1);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      check("R12 no write after halt", dmem_we, 0);
      check("R12 halt sticky", halted, 1);
      check("R12 fetch frozen", imem_addr, 32'h0);
    end

    // R3: exhaustive single immediate
    for (int b = 0; b < 128; b++) begin
      clr_prog(); put(8'h80 | 8'(b)); put(8'h00);
      run();
      check("R3 imm sext", rd(32'h3FC), m_sext(7'(b)));
      check("R3 cycles", cyc, 10);
    end
    // R3: two-byte chains
    for (int b = 0; b < 128; b += 9) begin
      clr_prog(); put(8'h80 | 8'(b)); put(8'h80 | 8'(127 - b)); put(8'h02); put(8'h00);
      run();
      check("R3 chain value", rd(32'h3FC), (m_sext(7'(b)) << 7) | 32'(127 - b));
      check("R3 chain one push", rd(32'h3F8), 32'h3FC);
    end
    // R13: NOP codes break a chain and change nothing
    foreach (vals[i]) begin
      logic [7:0] nops [0:4];
      nops = '{8'h01, 8'h03, 8'h0B, 8'h0E, 8'h0F};
      clr_prog(); put(8'h85); put(nops[i % 5]); put(8'h86); put(8'h02); put(8'h00);
      run();
      check("R13 first word", rd(32'h3FC), 32'h5);
      check("R13 second word", rd(32'h3F8), 32'h6);
      check("R13 sp", rd(32'h3F4), 32'h3F8);
    end

    // R4: binary ops
    foreach (vals[i]) begin
      logic [31:0] x, y;
      x = vals[i]; y = vals[(i * 3 + 1) % 8];
      bin_test("R4 add", 8'h05, x, y, x + y);
      bin_test("R4 and", 8'h06, x, y, x & y);
      bin_test("R4 or",  8'h07, x, y, x | y);
      bin_test("R4 sub native", 8'h31, x, y, x - y);
    end

    // R5: not and bit reverse
    foreach (vals[i]) begin
      clr_prog(); put_const(vals[i]); put(8'h09); put(8'h00);
      run();
      check("R5 not", rd(32'h3FC), ~vals[i]);
      clr_prog(); put_const(vals[i]); put(8'h0A); put(8'h00);
      run();
      check("R5 flip", rd(32'h3FC), m_rev(vals[i]));
    end

    // R6: load from stack slot, all 32 offsets
    for (int o = 0; o < 32; o++) begin
      clr_prog(); put(8'h60 | 8'(o)); put(8'h02); put(8'h00);
      run();
      check("R6 loadsp value", rd(32'h3FC), pat(256 + o));
      check("R6 loadsp sp", rd(32'h3F8), 32'h3FC);
      check("R6 cycles", cyc, 15);
    end

    // R7: store to stack slot, offsets 1..31
    for (int o = 1; o < 32; o++) begin
      clr_prog(); put(8'h80 | 8'(o + 3)); put(8'h40 | 8'(o)); put(8'h02); put(8'h00);
      run();
      check("R7 storesp target", rd(32'h3FC + 4 * o), 32'(o + 3));
      check("R7 storesp sp", rd(32'h3FC), 32'h400);
    end

    // R8: add stack slot, all 16 offsets
    for (int o = 0; o < 16; o++) begin
      logic [31:0] e;
      e = (o == 0) ? 32'd40 : 32'd20 + pat(255 + o);
      clr_prog(); put(8'h80 | 8'd20); put(8'h10 | 8'(o)); put(8'h00);
      run();
      check("R8 addsp", rd(32'h3FC), e);
    end

    // R9: store then load back
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = 32'h200 + 32'(k * 12);
      clr_prog(); put_const(vals[k + 4]); put_const(a); put(8'h0C);
      put_const(a); put(8'h08); put(8'h02); put(8'h00);
      run();
      check("R9 store", rd(a), vals[k + 4]);
      check("R9 load", rd(32'h3FC), vals[k + 4]);
      check("R9 sp", rd(32'h3F8), 32'h3FC);
    end

    // R10: PUSHSP, POPSP, POPPC
    clr_prog(); put_const(32'h300); put(8'h0D); put(8'h02); put(8'h00);
    run();
    check("R10 popsp", rd(32'h2FC), 32'h300);
    clr_prog(); put_const(32'h100); put(8'h04); put(8'h89); put(8'h00);
    pos = 32'h100; put(8'h85); put(8'h00);
    run();
    check("R10 poppc target", rd(32'h3FC), 32'h5);
    check("R10 poppc cycles", cyc, 45);

    // R11: traps over the whole range except the native code
    for (int k = 0; k < 32; k++) begin
      if (k == 17) continue;
      clr_prog(); put(8'h0B); put(8'h20 | 8'(k));
      pos = 32'h400 + 32 * k; put(8'h80 | 8'(k)); put(8'h00);
      run();
      check("R11 return addr", rd(32'h3FC), 32'h2);
      check("R11 handler ran", rd(32'h3F8), 32'(k));
      check("R11 cycles", cyc, 20);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule